// File: doc/BRIEF.md
# Reservation Station Issue Controller

This block is the issue stage of a small out-of-order core built around reservation stations. Every cycle it looks at the instruction sitting at the current program counter. It works out which class of station the opcode needs, searches that class for a station that is not busy, and either issues the instruction into that station or stalls. It owns the program counter.

Jumps are not predicted. When a jump issues, the program counter is marked as waiting on the integer station, and issue freezes. It resumes once the integer unit reports completion and its result has been loaded as the new program counter. As a separate combinational service, the block also turns a register's producer tag into the code of the functional unit that will write that register.

Stations carry fixed nonzero identifiers laid out class by class: the integer station first, then the add, multiply and memory stations. Zero is kept to mean "no producer". With the default parameters the integer station is 1, the add stations are 2 to 4, the multiply stations are 5 and 6, and the memory stations are 7 to 9. Bit i of the busy vector and of the allocate strobe belongs to station i+1.

Top module: `rs_issue_ctrl`

## Requirements
- R1: Opcode codes map to station classes as follows: addi=1 and jump=2 go to the integer class, fadd=3 to the add class, fmul=4 to the multiply class, and load=5 and store=6 to the memory class.
- R2: Within the required class, the free station with the lowest identifier is chosen and reported on `issue_id` with `issue_valid` high. If every station of that class is busy, `issue_valid` stays low.
- R3: `alloc` is one-hot at bit `issue_id-1` when an instruction issues and all zero otherwise. It never selects a busy station.
- R4: Opcodes 0 and 7, or `instr_valid` low, cause no issue and leave the PC unchanged.
- R5: On each issue, the PC advances by one at the next clock edge.
- R6: When a jump issues, `pc_tag` becomes 1, the integer station identifier.
- R7: While `pc_tag` is nonzero, nothing issues and `alloc` is zero.
- R8: While `pc_tag` is nonzero, a cycle with `int_done` high loads `int_result` into the PC and clears `pc_tag` to zero.
- R9: In any other cycle, `pc` and `pc_tag` hold. This includes `int_done` arriving while no jump is pending.
- R10: `wr_unit` decodes `reg_tag` as follows: 0 gives 0 (none), 1 gives 1 (integer), 2 to 4 give 2 (add), 5 to 6 give 3 (multiply), 7 to 9 give 4 (memory), and any other tag gives 0.
- R11: A synchronous active-high `rst` sets `pc` and `pc_tag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is present at the PC |
| instr_op | input | 3 | Opcode of that instruction |
| busy | input | 9 | Busy flag per station, bit i for station i+1 |
| int_done | input | 1 | Integer unit completion |
| int_result | input | 8 | Integer unit result (jump target) |
| reg_tag | input | 4 | Producer tag of a register to decode |
| pc | output | 8 | Program counter |
| pc_tag | output | 4 | Pending producer tag of the PC |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_id | output | 4 | Identifier of the chosen station |
| alloc | output | 9 | One-cycle allocate strobe per station |
| wr_unit | output | 3 | Unit code decoded from `reg_tag` |

## Verification
The assertions assume that `busy` and `instr_op` are settled well before the sampling edge. They also assume that `int_done` matters only as a strobe, so its value in cycles without a pending jump must change nothing. The stimulus drives every input on the falling clock edge and holds it steady through the following rising edge. While a jump is pending, it deliberately keeps offering valid, issuable instructions and raises `int_done` with no jump outstanding, so that the stall and hold properties are tested by inputs that would otherwise cause a change.

// File: rtl/rs_issue_ctrl.sv
module rs_issue_ctrl #(
  parameter int PC_W  = 8,
  parameter int TAG_W = 4,
  parameter int INT_N = 1,
  parameter int ADD_N = 3,
  parameter int MUL_N = 2,
  parameter int MEM_N = 3,
  localparam int N    = INT_N + ADD_N + MUL_N + MEM_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [2:0]       instr_op,
  input  logic [N-1:0]     busy,
  input  logic             int_done,
  input  logic [PC_W-1:0]  int_result,
  input  logic [TAG_W-1:0] reg_tag,
  output logic [PC_W-1:0]  pc,
  output logic [TAG_W-1:0] pc_tag,
  output logic             issue_valid,
  output logic [TAG_W-1:0] issue_id,
  output logic [N-1:0]     alloc,
  output logic [2:0]       wr_unit
);
  localparam int INT_BASE = 1;
  localparam int ADD_BASE = INT_BASE + INT_N;
  localparam int MUL_BASE = ADD_BASE + ADD_N;
  localparam int MEM_BASE = MUL_BASE + MUL_N;
  localparam int ID_END   = MEM_BASE + MEM_N;

  int   base, cnt, pick;
  logic known, found;

  always_comb begin
    known = 1'b1;
    base  = 0;
    cnt   = 0;
    case (instr_op)
      3'd1, 3'd2: begin base = INT_BASE; cnt = INT_N; end
      3'd3:       begin base = ADD_BASE; cnt = ADD_N; end
      3'd4:       begin base = MUL_BASE; cnt = MUL_N; end
      3'd5, 3'd6: begin base = MEM_BASE; cnt = MEM_N; end
      default:    known = 1'b0;
    endcase
    found = 1'b0;
    pick  = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (i + 1 >= base && i + 1 < base + cnt && !busy[i]) begin
        found = 1'b1;
        pick  = i;
      end
    end
  end

  wire pending = (pc_tag != '0);
  wire resolve = pending && int_done;
  assign issue_valid = !pending && instr_valid && known && found;
  assign issue_id    = issue_valid ? TAG_W'(pick + 1) : '0;
  assign alloc       = issue_valid ? (N'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      pc_tag <= '0;
    end else if (issue_valid) begin
      pc <= pc + 1'b1;
      if (instr_op == 3'd2) pc_tag <= TAG_W'(INT_BASE);
    end else if (resolve) begin
      pc     <= int_result;
      pc_tag <= '0;
    end
  end

  int t;
  always_comb begin
    t = int'(reg_tag);
    if (t >= INT_BASE && t < ADD_BASE)      wr_unit = 3'd1;
    else if (t >= ADD_BASE && t < MUL_BASE) wr_unit = 3'd2;
    else if (t >= MUL_BASE && t < MEM_BASE) wr_unit = 3'd3;
    else if (t >= MEM_BASE && t < ID_END)   wr_unit = 3'd4;
    else                                    wr_unit = 3'd0;
  end
endmodule

module rs_issue_ctrl_chk #(
  parameter int PC_W  = 8,
  parameter int TAG_W = 4,
  parameter int N     = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       instr_op,
  input logic [N-1:0]     busy,
  input logic             int_done,
  input logic [PC_W-1:0]  int_result,
  input logic [TAG_W-1:0] reg_tag,
  input logic [PC_W-1:0]  pc,
  input logic [TAG_W-1:0] pc_tag,
  input logic             issue_valid,
  input logic [N-1:0]     alloc,
  input logic [2:0]       wr_unit
);
  // R3
  alloc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc) && ((alloc & busy) == '0));
  // R7
  stall_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_tag != '0) |-> (!issue_valid && alloc == '0));
  // R5
  pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> pc == $past(pc) + 1'b1);
  // R6
  jump_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && instr_op == 3'd2) |=> pc_tag == TAG_W'(1));
  // R8
  resolve_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_tag != '0 && int_done) |=> (pc == $past(int_result) && pc_tag == '0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!issue_valid && !(pc_tag != '0 && int_done)) |=> ($stable(pc) && $stable(pc_tag)));
  // R10
  no_producer_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_tag == '0) |-> (wr_unit == 3'd0));
endmodule

bind rs_issue_ctrl rs_issue_ctrl_chk #(.PC_W(PC_W), .TAG_W(TAG_W), .N(N)) u_chk (.*);

// File: tb/test_rs_issue_ctrl.sv
`timescale 1ns/1ps
module test_rs_issue_ctrl;
  localparam int N = 9;
  logic       clk = 1'b0, rst = 1'b1;
  logic       instr_valid = 1'b0, int_done = 1'b0;
  logic [2:0] instr_op = 3'd0;
  logic [N-1:0] busy = '0;
  logic [7:0] int_result = '0;
  logic [3:0] reg_tag = '0;
  logic [7:0] pc;
  logic [3:0] pc_tag, issue_id;
  logic       issue_valid;
  logic [N-1:0] alloc;
  logic [2:0] wr_unit;
  int checks = 0, failures = 0;

  rs_issue_ctrl i_rs_issue_ctrl (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {valid, op[2:0], busy[8:0], exp_valid, exp_id[3:0]}
  localparam logic [17:0] VEC [16] = '{
    {1'b1, 3'd1, 9'b000000000, 1'b1, 4'd1},
    {1'b1, 3'd1, 9'b000000001, 1'b0, 4'd0},
    {1'b1, 3'd3, 9'b000000000, 1'b1, 4'd2},
    {1'b1, 3'd3, 9'b000000010, 1'b1, 4'd3},
    {1'b1, 3'd3, 9'b000000110, 1'b1, 4'd4},
    {1'b1, 3'd3, 9'b000001110, 1'b0, 4'd0},
    {1'b1, 3'd4, 9'b000000000, 1'b1, 4'd5},
    {1'b1, 3'd4, 9'b000010000, 1'b1, 4'd6},
    {1'b1, 3'd5, 9'b000000000, 1'b1, 4'd7},
    {1'b1, 3'd6, 9'b001000000, 1'b1, 4'd8},
    {1'b1, 3'd6, 9'b011000000, 1'b1, 4'd9},
    {1'b1, 3'd5, 9'b111000000, 1'b0, 4'd0},
    {1'b1, 3'd0, 9'b000000000, 1'b0, 4'd0},
    {1'b1, 3'd7, 9'b000000000, 1'b0, 4'd0},
    {1'b0, 3'd3, 9'b000000000, 1'b0, 4'd0},
    {1'b1, 3'd3, 9'b111110001, 1'b1, 4'd2}
  };

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int exp_pc;
    @(posedge clk); @(posedge clk); #1;
    chk("R11 pc reset", int'(pc), 0);
    chk("R11 tag reset", int'(pc_tag), 0);
    @(negedge clk) rst = 1'b0;
    exp_pc = 0;
    foreach (VEC[k]) begin
      @(negedge clk);
      instr_valid = VEC[k][17];
      instr_op    = VEC[k][16:14];
      busy        = VEC[k][13:5];
      #1;
      chk("R1 R2 issue_valid", int'(issue_valid), int'(VEC[k][4]));
      chk("R2 issue_id", VEC[k][4] ? int'(issue_id) : 0, int'(VEC[k][3:0]));
      chk("R3 alloc", int'(alloc), VEC[k][4] ? (1 << (int'(VEC[k][3:0]) - 1)) : 0);
      @(posedge clk); #1;
      if (VEC[k][4]) exp_pc++;
      chk("R4 R5 pc", int'(pc), exp_pc);
    end
    // R9: completion without a pending jump is ignored
    @(negedge clk);
    instr_valid = 1'b0; int_done = 1'b1; int_result = 8'h55;
    @(posedge clk); #1;
    chk("R9 pc hold on stray done", int'(pc), exp_pc);
    chk("R9 tag hold on stray done", int'(pc_tag), 0);
    // R6: jump
    @(negedge clk);
    int_done = 1'b0; instr_valid = 1'b1; instr_op = 3'd2; busy = '0;
    #1 chk("R1 jump issues", int'(issue_valid), 1);
    @(posedge clk); #1;
    exp_pc++;
    chk("R5 pc after jump", int'(pc), exp_pc);
    chk("R6 tag after jump", int'(pc_tag), 1);
    // R7: stall while pending
    @(negedge clk);
    instr_op = 3'd3;
    #1;
    chk("R7 no issue pending", int'(issue_valid), 0);
    chk("R7 no alloc pending", int'(alloc), 0);
    @(posedge clk); #1;
    chk("R9 pc hold pending", int'(pc), exp_pc);
    chk("R9 tag hold pending", int'(pc_tag), 1);
    // R8: resolution
    @(negedge clk);
    int_done = 1'b1; int_result = 8'h40;
    @(posedge clk); #1;
    chk("R8 pc loaded", int'(pc), 'h40);
    chk("R8 tag cleared", int'(pc_tag), 0);
    @(negedge clk);
    int_done = 1'b0; instr_op = 3'd1;
    #1 chk("R7 issue resumes", int'(issue_valid), 1);
    @(posedge clk); #1;
    chk("R5 pc after resume", int'(pc), 'h41);
    // R10: tag decode
    for (int t = 0; t < 16; t++) begin
      int e;
      @(negedge clk);
      reg_tag = 4'(t);
      #1;
      e = (t == 1) ? 1 : (t >= 2 && t <= 4) ? 2 : (t >= 5 && t <= 6) ? 3 :
          (t >= 7 && t <= 9) ? 4 : 0;
      chk("R10 wr_unit", int'(wr_unit), e);
    end
    // R11: reset while a jump is pending
    @(negedge clk);
    instr_valid = 1'b1; instr_op = 3'd2;
    @(posedge clk); #1;
    chk("R6 tag set again", int'(pc_tag), 1);
    @(negedge clk);
    rst = 1'b1; instr_valid = 1'b0;
    @(posedge clk); #1;
    chk("R11 pc reset mid-run", int'(pc), 0);
    chk("R11 tag reset mid-run", int'(pc_tag), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule